// File: doc/BRIEF.md
# Multi-set crossbar grant arbiter

This block is the output half of a crossbar scheduler whose request side lives far away. That distance makes the result of each request known only after several cell slots. To keep the round-robin pointers from falling into lockstep while results are still in flight, every output keeps one grant pointer per pointer set. Every batch of requests carries the number of the set that produced it. The arbiter uses that set's pointer at each output, so each set advances apart from the others.

All output selectors sit in this one module. A cell slot may contain several matching iterations. The arbiter remembers which inputs and which outputs were already matched in earlier iterations of the current slot. A later iteration can therefore add edges to the matching without breaking the one-to-one property. Within a single iteration, outputs are resolved in index order. An input claimed by a lower-numbered output is invisible to the higher ones, and those continue their round-robin search past it.

A request batch is an N×N bit matrix in which bit `o*N+i` means input `i` asks for output `o`. It comes with a valid strobe, a first-iteration flag and the set number. One clock later the grant matrix appears, in the same layout and tagged with the same set number.

Top module: `mset_grant_arb`

## Requirements
- R1: After reset `gnt_valid` is 0 and `gnt_mat` is all zero, and every grant pointer of every set holds input 0.
- R2: A batch presented with `req_valid`=1 produces its result on the next clock edge: `gnt_valid`=1 and `gnt_set` equal to the batch's `req_set`.
- R3: Each output grants at most one input, and only an input whose request bit `req_mat[o*N+i]` was set in that batch.
- R4: Each output grants the first eligible requesting input found when scanning upward from the pointer of the batch's set, wrapping from N-1 to 0.
- R5: When output `o` grants input `i` in a first iteration, pointer `o` of that batch's set becomes `(i+1) mod N`. Pointers of every other set are left as they were.
- R6: Grants made in a batch with `iter_first`=0 leave all pointers unchanged.
- R7: No input is granted by two outputs in one batch. The lower output index wins, and a higher output continues its scan past the claimed input.
- R8: In a batch with `iter_first`=0, inputs and outputs matched by earlier batches since the last first iteration take no part: such an output grants nothing, and such an input is granted by no output.
- R9: A batch with `iter_first`=1 starts a new slot. All matched-input and matched-output history is discarded before it is arbitrated.
- R10: A cycle with `req_valid`=0 yields `gnt_valid`=0 and an all-zero `gnt_mat` on the next edge. It changes neither pointers nor matched history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request batch is present this cycle |
| iter_first | input | 1 | Batch is the first iteration of a new slot |
| req_set | input | SW | Pointer-set number the batch was built with |
| req_mat | input | N*N | Request bits, bit o*N+i = input i asks output o |
| gnt_valid | output | 1 | Grant matrix is valid |
| gnt_set | output | SW | Set number echoed from the request batch |
| gnt_mat | output | N*N | Grant bits, bit o*N+i = output o grants input i |

## Verification
Every result is due exactly one clock edge after the cycle in which its batch was driven, because the only register between request and grant is the output register. Pointer and history updates made by a batch affect only the batch that follows it. The bench drives each batch on a falling edge and queues the expected grant matrix, worked out from its own pointer and history model. The monitor pops one entry two nanoseconds after each rising edge. That is the instant the registered result of the batch driven half a cycle earlier is stable, so queue order and sampling time line up with the one-edge latency. Idle cycles queue an entry too, so a result appearing a cycle early or late shows as a mismatch.

// File: rtl/mga_pkg.sv
package mga_pkg;

    // Round-robin successor of an index within 0..n-1.
    function automatic int wrap_next(input int idx, input int n);
        return (idx + 1) % n;
    endfunction

endpackage

// File: rtl/mga_rr_pick.sv
// Round-robin one-hot picker: first set bit at or after ptr, wrapping.
module mga_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  pick
);

    always_comb begin
        logic found;
        int   idx;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    a_r3_pick_onehot : assert final ($onehot0(pick));

endmodule

// File: rtl/mga_ptr_bank.sv
// Grant pointer storage: SETS independent pointer sets, one pointer per output.
module mga_ptr_bank #(
    parameter int N    = 4,
    parameter int SETS = 4,
    parameter int PW   = 2,
    parameter int SW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   rd_set,
    output logic [N*PW-1:0] ptr_vec,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_set,
    input  logic [N-1:0]    wr_mask,
    input  logic [N*PW-1:0] wr_val
);

    logic [PW-1:0] ptr_d [SETS][N];
    logic [PW-1:0] ptr_q [SETS][N];

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) begin
            for (int o = 0; o < N; o++) begin
                if (wr_mask[o]) begin
                    ptr_d[wr_set][o] = wr_val[o*PW +: PW];
                end
            end
        end
    end

    always_comb begin
        for (int o = 0; o < N; o++) begin
            ptr_vec[o*PW +: PW] = ptr_q[rd_set][o];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int o = 0; o < N; o++) begin
                    ptr_q[s][o] <= '0;
                end
            end
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // R5: a written set sees its pointer change, other sets hold.
    generate
        for (genvar s = 0; s < SETS; s++) begin : g_hold
            a_r5_other_sets_hold : assert property (@(posedge clk) disable iff (!rst_n)
                (wr_set != SW'(s) || !wr_en) |=> $stable(ptr_q[s][0]));
        end
    endgenerate

endmodule

// File: rtl/mset_grant_arb.sv
// Centralized grant arbiter with per-set pointers and shared matched history.
module mset_grant_arb
    import mga_pkg::*;
#(
    parameter int N    = 4,
    parameter int SETS = 4,
    localparam int PW  = (N > 1) ? $clog2(N) : 1,
    localparam int SW  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int NN  = N * N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          iter_first,
    input  logic [SW-1:0] req_set,
    input  logic [NN-1:0] req_mat,
    output logic          gnt_valid,
    output logic [SW-1:0] gnt_set,
    output logic [NN-1:0] gnt_mat
);

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] set;
        logic [NN-1:0] gnt;
        logic [N-1:0]  in_m;
        logic [N-1:0]  out_m;
    } arb_state_t;

    arb_state_t s_d, s_q;

    logic [N*PW-1:0] ptr_vec;
    logic [N*PW-1:0] ptr_nxt;
    logic [NN-1:0]   pick_flat;
    logic [N-1:0]    out_hit;
    logic [N-1:0]    in_used;
    logic [N-1:0]    in_m_eff;
    logic [N-1:0]    out_m_eff;

    // A first iteration starts from empty history (R9).
    assign in_m_eff  = iter_first ? '0 : s_q.in_m;
    assign out_m_eff = iter_first ? '0 : s_q.out_m;

    // Output selectors, resolved in index order so lower outputs win (R7).
    generate
        for (genvar o = 0; o < N; o++) begin : g_out
            logic [N-1:0]  taken_in;
            logic [N-1:0]  taken_out;
            logic [N-1:0]  cand;
            logic [N-1:0]  pick;
            logic [PW-1:0] nxt;

            if (o == 0) begin : g_first
                assign taken_in = '0;
            end else begin : g_chain
                assign taken_in = g_out[o-1].taken_out;
            end

            assign cand = (req_valid && !out_m_eff[o])
                        ? (req_mat[o*N +: N] & ~in_m_eff & ~taken_in)
                        : '0;

            mga_rr_pick #(.N(N), .PW(PW)) u_pick (
                .req  (cand),
                .ptr  (ptr_vec[o*PW +: PW]),
                .pick (pick)
            );

            assign taken_out           = taken_in | pick;
            assign pick_flat[o*N +: N] = pick;
            assign out_hit[o]          = |pick;

            always_comb begin
                nxt = '0;
                for (int i = 0; i < N; i++) begin
                    if (pick[i]) nxt = PW'(wrap_next(i, N));
                end
            end
            assign ptr_nxt[o*PW +: PW] = nxt;
        end
    endgenerate

    assign in_used = g_out[N-1].taken_out;

    // Pointers move only on first-iteration grants (R5, R6).
    mga_ptr_bank #(.N(N), .SETS(SETS), .PW(PW), .SW(SW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (req_set),
        .ptr_vec (ptr_vec),
        .wr_en   (req_valid && iter_first),
        .wr_set  (req_set),
        .wr_mask (out_hit),
        .wr_val  (ptr_nxt)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = req_valid;
        s_d.gnt = '0;
        if (req_valid) begin
            s_d.set   = req_set;
            s_d.gnt   = pick_flat;
            s_d.in_m  = in_m_eff | in_used;
            s_d.out_m = out_m_eff | out_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt_valid = s_q.vld;
    assign gnt_set   = s_q.set;
    assign gnt_mat   = s_q.gnt;

    // ---------------- assertions ----------------
    logic [N-1:0] gnt_any_in;
    always_comb begin
        gnt_any_in = '0;
        for (int o = 0; o < N; o++) gnt_any_in |= gnt_mat[o*N +: N];
    end

    a_r2_set_echo : assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> gnt_set == $past(req_set));

    a_r8_no_rematch : assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !$past(iter_first)) |-> (gnt_any_in & $past(s_q.in_m)) == '0);

    a_r10_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> gnt_mat == '0);

    generate
        for (genvar o = 0; o < N; o++) begin : g_row_chk
            a_r3_row_onehot : assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(gnt_mat[o*N +: N]));
            a_r3_was_requested : assert property (@(posedge clk) disable iff (!rst_n)
                gnt_valid |-> (gnt_mat[o*N +: N] & ~$past(req_mat[o*N +: N])) == '0);
        end
        for (genvar i = 0; i < N; i++) begin : g_col_chk
            logic [N-1:0] col;
            always_comb begin
                for (int o = 0; o < N; o++) col[o] = gnt_mat[o*N + i];
            end
            a_r7_col_onehot : assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(col));
        end
    endgenerate

endmodule

// File: tb/test_mset_grant_arb.sv
`timescale 1ns/1ps
module test_mset_grant_arb;

    localparam int N    = 4;
    localparam int SETS = 4;
    localparam int SW   = 2;
    localparam int NN   = N * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          iter_first = 1'b0;
    logic [SW-1:0] req_set = '0;
    logic [NN-1:0] req_mat = '0;
    logic          gnt_valid;
    logic [SW-1:0] gnt_set;
    logic [NN-1:0] gnt_mat;

    mset_grant_arb #(.N(N), .SETS(SETS)) i_mset_grant_arb (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .iter_first(iter_first),
        .req_set(req_set), .req_mat(req_mat), .gnt_valid(gnt_valid),
        .gnt_set(gnt_set), .gnt_mat(gnt_mat)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit            vld;
        logic [SW-1:0] set;
        logic [NN-1:0] gnt;
        string         tag;
    } exp_t;

    exp_t expq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Reference state
    int ptr_m [SETS][N];
    bit inm [N];
    bit outm [N];

    task automatic drive(input bit v, input bit first, input int set,
                         input logic [NN-1:0] req, input string tag);
        exp_t e;
        bit   taken [N];
        e.vld = v; e.set = SW'(set); e.gnt = '0; e.tag = tag;
        @(negedge clk);
        req_valid = v; iter_first = first; req_set = SW'(set); req_mat = req;
        if (v) begin
            if (first) begin
                for (int k = 0; k < N; k++) begin inm[k] = 0; outm[k] = 0; end
            end
            for (int k = 0; k < N; k++) taken[k] = 0;
            for (int o = 0; o < N; o++) begin
                if (!outm[o]) begin
                    for (int k = 0; k < N; k++) begin
                        int i;
                        i = (ptr_m[set][o] + k) % N;
                        if (req[o*N+i] && !inm[i] && !taken[i]) begin
                            e.gnt[o*N+i] = 1'b1;
                            taken[i] = 1;
                            outm[o] = 1;
                            if (first) ptr_m[set][o] = (i + 1) % N;
                            break;
                        end
                    end
                end
            end
            for (int k = 0; k < N; k++) if (taken[k]) inm[k] = 1;
        end
        expq.push_back(e);
    endtask

    // Monitor: result of the batch driven half a cycle earlier.
    always @(posedge clk) begin
        #2;
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            n_chk++;
            if (gnt_valid !== e.vld || gnt_mat !== e.gnt ||
                (e.vld && gnt_set !== e.set)) begin
                n_bad++;
                $display("FAIL %s: got vld=%0b set=%0d gnt=%h, expected vld=%0b set=%0d gnt=%h",
                         e.tag, gnt_valid, gnt_set, gnt_mat, e.vld, e.set, e.gnt);
            end
        end
    end

    function automatic logic [31:0] step(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got no end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        int          cur_set;
        for (int s = 0; s < SETS; s++)
            for (int o = 0; o < N; o++) ptr_m[s][o] = 0;
        for (int k = 0; k < N; k++) begin inm[k] = 0; outm[k] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (gnt_valid !== 1'b0 || gnt_mat !== '0) begin
            n_bad++;
            $display("FAIL R1: got vld=%0b gnt=%h, expected vld=0 gnt=0", gnt_valid, gnt_mat);
        end

        // Full request, pointers from reset: diagonal via lower-output-wins.
        drive(1, 1, 0, {NN{1'b1}}, "R1 R4 R7");
        drive(1, 1, 1, {NN{1'b1}}, "R5 set independence");
        drive(1, 1, 0, {NN{1'b1}}, "R5 R4 advanced pointers");
        drive(1, 1, 0, 16'h0303, "R7 contention");
        drive(0, 0, 0, {NN{1'b1}}, "R10 idle");
        drive(1, 1, 2, 16'h0003, "R2 R4 first iteration");
        drive(1, 0, 2, {NN{1'b1}}, "R8 second iteration");
        drive(1, 0, 2, {NN{1'b1}}, "R8 third iteration");
        drive(1, 1, 2, {NN{1'b1}}, "R6 R9 new slot");
        drive(1, 1, 3, 16'h8421, "R3 sparse request");
        drive(1, 1, 3, 16'h0000, "R3 empty request");

        lf = 32'h1234_5679;
        cur_set = 0;
        for (int n = 0; n < 300; n++) begin
            bit first;
            lf = step(lf);
            first = (n % 3 == 0);
            if (first) cur_set = int'(lf[31:30]);
            if (lf[29:27] == 3'd0) drive(0, 0, cur_set, lf[15:0], "R10 random idle");
            else drive(1, first, cur_set, lf[15:0], "R4 R8 random");
        end
        drive(0, 0, 0, '0, "R10 tail");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule